// File: doc/BRIEF.md
# Static Round-Trip Delay Calculator

This block turns stored trace geometry into a per-byte-lane round-trip delay in picoseconds. No measurement is involved. A small internal table holds four values for every global lane: board clock trace length, board strobe trace length, package clock delay and package strobe delay. Software or a boot sequencer fills the table through a valid/ready load port. It then selects a mode, sets the interface and lane masks, and pulses `start`.

The block then walks every interface and every lane in index order. It skips any lane whose interface bit or lane bit is clear. For each active lane it forms the board length, with the strobe term signed by the mode. It scales that length by 163/1000 using a multi-cycle restoring divider, then adds the package terms and a mode-dependent offset. Negative results are clamped to zero, and the value is stored in the output delay array. In write-leveling mode the strobe terms are subtracted from the clock terms and the debug offset is added. In read-leveling mode the strobe terms are added and the silicon offset is used. A single-cycle `done` follows the end of the walk.

The load port follows these back-pressure rules:
- A beat is taken on a rising clock edge when `ld_valid` and `ld_ready` are both high.
- `ld_ready` is low for the whole time `busy` is high.
- A beat that is offered while `ld_ready` is low is not taken, and the table keeps its contents.
- The source may hold `ld_valid` and its data until the beat is taken.

Top module: `rtd_calc`

## Requirements
- R1: After reset, `busy` and `done` are 0, `ld_ready` is 1 and every slot of `dly_o` is 0.
- R2: With `wl_mode`=0 (read), a lane's result is trunc((brd_ck+brd_dqs)*163/1000) + pkg_ck + pkg_dqs + `rd_extra`.
- R3: With `wl_mode`=1 (write), a lane's result is trunc0((brd_ck-brd_dqs)*163/1000) + pkg_ck - pkg_dqs + `wl_extra`. Here trunc0 rounds toward zero, so a negative board length gives a negative term.
- R4: A total below zero is stored as 0.
- R5: Interface i, lane j is stored in slot g = i*LANES + j, which is bits `dly_o[g*DLY_W +: DLY_W]`. The table entry for that lane is loaded with `ld_lane` = g.
- R6: A lane is computed only when both `if_mask[i]` and `lane_mask[j]` are 1. Every other slot keeps its value, and all slots hold while idle.
- R7: `busy` rises in the cycle after `start` is taken while idle. `done` is a single-cycle pulse, issued after the last lane index has been visited, even when no lane is active.
- R8: `ld_ready` is 0 while `busy` is 1, and a load offered then does not change the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_valid | input | 1 | Table load beat valid |
| ld_ready | output | 1 | Table load beat accepted when high |
| ld_lane | input | IDX_W | Global lane index of the entry being loaded |
| ld_brd_ck | input | TRACE_W | Board clock trace length |
| ld_brd_dqs | input | TRACE_W | Board strobe trace length |
| ld_pkg_ck | input | PKG_W | Package clock delay, ps |
| ld_pkg_dqs | input | PKG_W | Package strobe delay, ps |
| wl_mode | input | 1 | 1 = write-leveling sums, 0 = read-leveling sums; sampled at start |
| if_mask | input | N_IF | Interface-active mask; sampled at start |
| lane_mask | input | LANES | Lane-active mask; sampled at start |
| wl_extra | input | OFF_W | Debug offset used in write mode, ps |
| rd_extra | input | OFF_W | Silicon offset used in read mode, ps |
| start | input | 1 | Begin a pass (taken when idle) |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| dly_o | output | N_IF*LANES*DLY_W | Flattened delay array, slot g at [g*DLY_W +: DLY_W] |

## Verification
The embedded properties watch several behaviours on every cycle:
- The divider remainder stays below the divisor whenever a quotient is delivered.
- `done` never lasts more than one cycle.
- A taken `start` always raises `busy`.
- The delay array is frozen while idle.
- The trace table cannot change while a pass is running.

The arithmetic needs the bench's scenarios, because only concrete stimulus can show it:
- the sign handling that differs between the two modes,
- truncation toward zero of a negative board term,
- clamping,
- slot placement under partial masks,
- the effect of a load refused during a pass.

// File: rtl/rtd_pkg.sv
package rtd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PICK,
    ST_WAIT,
    ST_NEXT
  } rtd_state_e;

  localparam int unsigned SCALE_NUM = 163;
  localparam int unsigned SCALE_DEN = 1000;
endpackage

// File: rtl/rtd_trace_table.sv
module rtd_trace_table #(
  parameter int N       = 16,
  parameter int IDX_W   = 4,
  parameter int TRACE_W = 12,
  parameter int PKG_W   = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic               lock,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [TRACE_W-1:0] wr_bck,
  input  logic [TRACE_W-1:0] wr_bdqs,
  input  logic [PKG_W-1:0]   wr_pck,
  input  logic [PKG_W-1:0]   wr_pdqs,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [TRACE_W-1:0] rd_bck,
  output logic [TRACE_W-1:0] rd_bdqs,
  output logic [PKG_W-1:0]   rd_pck,
  output logic [PKG_W-1:0]   rd_pdqs
);
  logic [N-1:0][TRACE_W-1:0] bck_mem, bdqs_mem;
  logic [N-1:0][PKG_W-1:0]   pck_mem, pdqs_mem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bck_mem  <= '0;
      bdqs_mem <= '0;
      pck_mem  <= '0;
      pdqs_mem <= '0;
    end else if (we && !lock && (int'(wr_idx) < N)) begin
      bck_mem[wr_idx]  <= wr_bck;
      bdqs_mem[wr_idx] <= wr_bdqs;
      pck_mem[wr_idx]  <= wr_pck;
      pdqs_mem[wr_idx] <= wr_pdqs;
    end
  end

  assign rd_bck  = bck_mem[rd_idx];
  assign rd_bdqs = bdqs_mem[rd_idx];
  assign rd_pck  = pck_mem[rd_idx];
  assign rd_pdqs = pdqs_mem[rd_idx];

  // R8: contents frozen while a pass holds the lock
  p_table_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> ($stable(bck_mem) && $stable(bdqs_mem) && $stable(pck_mem) && $stable(pdqs_mem)));
endmodule

// File: rtl/rtd_divider.sv
module rtd_divider #(
  parameter int W       = 23,
  parameter int DIVISOR = 1000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] dividend,
  output logic [W-1:0] quot,
  output logic         fin
);
  localparam int RW = $clog2(DIVISOR) + 1;
  localparam int CW = $clog2(W + 1);

  logic [RW-2:0] rem;
  logic [W-1:0]  quo;
  logic [CW-1:0] cnt;
  logic          run;
  logic [RW-1:0] shifted;
  logic          ge;
  logic [RW-2:0] rem_nx;

  always_comb begin
    shifted = {rem, quo[W-1]};
    ge      = shifted >= RW'(DIVISOR);
    rem_nx  = ge ? (RW-1)'(shifted - RW'(DIVISOR)) : shifted[RW-2:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem <= '0;
      quo <= '0;
      cnt <= '0;
      run <= 1'b0;
      fin <= 1'b0;
    end else if (go) begin
      rem <= '0;
      quo <= dividend;
      cnt <= CW'(W);
      run <= 1'b1;
      fin <= 1'b0;
    end else if (run) begin
      rem <= rem_nx;
      quo <= {quo[W-2:0], ge};
      cnt <= cnt - 1'b1;
      run <= (cnt != CW'(1));
      fin <= (cnt == CW'(1));
    end else begin
      fin <= 1'b0;
    end
  end

  assign quot = quo;

  // R2: a delivered quotient leaves a proper remainder
  p_rem_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (RW'(rem) < RW'(DIVISOR)));
endmodule

// File: rtl/rtd_lane_seq.sv
module rtd_lane_seq
  import rtd_pkg::*;
#(
  parameter int N_IF    = 4,
  parameter int LANES   = 4,
  parameter int IDX_W   = 4,
  parameter int TRACE_W = 12,
  parameter int PKG_W   = 10,
  parameter int OFF_W   = 12,
  parameter int DLY_W   = 16,
  parameter int SUM_W   = 23
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic                           wl_mode,
  input  logic [N_IF-1:0]                if_mask,
  input  logic [LANES-1:0]               lane_mask,
  input  logic [OFF_W-1:0]               wl_extra,
  input  logic [OFF_W-1:0]               rd_extra,
  input  logic [TRACE_W-1:0]             bck,
  input  logic [TRACE_W-1:0]             bdqs,
  input  logic [PKG_W-1:0]               pck,
  input  logic [PKG_W-1:0]               pdqs,
  input  logic [SUM_W-1:0]               div_quot,
  input  logic                           div_fin,
  output logic [IDX_W-1:0]               rd_idx,
  output logic                           div_go,
  output logic [SUM_W-1:0]               div_dividend,
  output logic                           busy,
  output logic                           done,
  output logic [N_IF*LANES-1:0][DLY_W-1:0] dly_arr
);
  localparam int IF_W = (N_IF  > 1) ? $clog2(N_IF)  : 1;
  localparam int LN_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic signed [SUM_W-1:0] DLY_MAX = SUM_W'((64'd1 << DLY_W) - 64'd1);

  rtd_state_e            state;
  logic [IF_W-1:0]       if_i;
  logic [LN_W-1:0]       ln_i;
  logic                  mode_q;
  logic [N_IF-1:0]       ifm_q;
  logic [LANES-1:0]      lnm_q;
  logic signed [SUM_W-1:0] off_q;
  logic                  neg_q;

  logic                  active, last;
  logic signed [SUM_W-1:0] bck_s, bdqs_s, pck_s, pdqs_s, brd_s, mag_s;
  logic signed [SUM_W-1:0] conv_s, total_s;
  logic [DLY_W-1:0]      store_v;

  assign rd_idx = IDX_W'(if_i) * IDX_W'(LANES) + IDX_W'(ln_i);
  assign active = ifm_q[if_i] & lnm_q[ln_i];
  assign last   = (if_i == IF_W'(N_IF - 1)) && (ln_i == LN_W'(LANES - 1));
  assign busy   = (state != ST_IDLE);

  always_comb begin
    bck_s  = $signed(SUM_W'(bck));
    bdqs_s = $signed(SUM_W'(bdqs));
    pck_s  = $signed(SUM_W'(pck));
    pdqs_s = $signed(SUM_W'(pdqs));
    brd_s  = mode_q ? (bck_s - bdqs_s) : (bck_s + bdqs_s);
    mag_s  = (brd_s < 0) ? -brd_s : brd_s;
    div_dividend = $unsigned(mag_s) * SUM_W'(SCALE_NUM);
    div_go = (state == ST_PICK) && active;
    conv_s = neg_q ? -$signed(div_quot) : $signed(div_quot);
    total_s = conv_s + pck_s + (mode_q ? -pdqs_s : pdqs_s) + off_q;
    if (total_s < 0)            store_v = '0;
    else if (total_s > DLY_MAX) store_v = '1;
    else                        store_v = total_s[DLY_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      if_i    <= '0;
      ln_i    <= '0;
      mode_q  <= 1'b0;
      ifm_q   <= '0;
      lnm_q   <= '0;
      off_q   <= '0;
      neg_q   <= 1'b0;
      done    <= 1'b0;
      dly_arr <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          mode_q <= wl_mode;
          ifm_q  <= if_mask;
          lnm_q  <= lane_mask;
          off_q  <= $signed(SUM_W'(wl_mode ? wl_extra : rd_extra));
          if_i   <= '0;
          ln_i   <= '0;
          state  <= ST_PICK;
        end
        ST_PICK: begin
          neg_q <= (brd_s < 0);
          state <= active ? ST_WAIT : ST_NEXT;
        end
        ST_WAIT: if (div_fin) begin
          dly_arr[rd_idx] <= store_v;
          state <= ST_NEXT;
        end
        ST_NEXT: begin
          if (last) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            if (ln_i == LN_W'(LANES - 1)) begin
              ln_i <= '0;
              if_i <= if_i + 1'b1;
            end else begin
              ln_i <= ln_i + 1'b1;
            end
            state <= ST_PICK;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: end-of-pass pulse lasts one cycle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7: a start taken while idle always opens a pass
  p_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R6: stored delays do not move while idle
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(dly_arr));
endmodule

// File: rtl/rtd_calc.sv
module rtd_calc #(
  parameter int N_IF    = 4,
  parameter int LANES   = 4,
  parameter int TRACE_W = 12,
  parameter int PKG_W   = 10,
  parameter int OFF_W   = 12,
  parameter int DLY_W   = 16,
  localparam int N_LN   = N_IF * LANES,
  localparam int IDX_W  = (N_LN > 1) ? $clog2(N_LN) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ld_valid,
  output logic                   ld_ready,
  input  logic [IDX_W-1:0]       ld_lane,
  input  logic [TRACE_W-1:0]     ld_brd_ck,
  input  logic [TRACE_W-1:0]     ld_brd_dqs,
  input  logic [PKG_W-1:0]       ld_pkg_ck,
  input  logic [PKG_W-1:0]       ld_pkg_dqs,
  input  logic                   wl_mode,
  input  logic [N_IF-1:0]        if_mask,
  input  logic [LANES-1:0]       lane_mask,
  input  logic [OFF_W-1:0]       wl_extra,
  input  logic [OFF_W-1:0]       rd_extra,
  input  logic                   start,
  output logic                   busy,
  output logic                   done,
  output logic [N_LN*DLY_W-1:0]  dly_o
);
  localparam int SCALE_W = $clog2(rtd_pkg::SCALE_NUM + 1);
  localparam int SUM_W   = TRACE_W + 1 + SCALE_W + 2;

  logic [IDX_W-1:0]   rd_idx;
  logic [TRACE_W-1:0] t_bck, t_bdqs;
  logic [PKG_W-1:0]   t_pck, t_pdqs;
  logic               div_go, div_fin;
  logic [SUM_W-1:0]   div_dividend, div_quot;
  logic [N_LN-1:0][DLY_W-1:0] dly_arr;

  assign ld_ready = !busy;
  assign dly_o    = dly_arr;

  rtd_trace_table #(.N(N_LN), .IDX_W(IDX_W), .TRACE_W(TRACE_W), .PKG_W(PKG_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .we(ld_valid && ld_ready), .lock(busy),
    .wr_idx(ld_lane), .wr_bck(ld_brd_ck), .wr_bdqs(ld_brd_dqs),
    .wr_pck(ld_pkg_ck), .wr_pdqs(ld_pkg_dqs),
    .rd_idx(rd_idx), .rd_bck(t_bck), .rd_bdqs(t_bdqs),
    .rd_pck(t_pck), .rd_pdqs(t_pdqs)
  );

  rtd_divider #(.W(SUM_W), .DIVISOR(rtd_pkg::SCALE_DEN)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go),
    .dividend(div_dividend), .quot(div_quot), .fin(div_fin)
  );

  rtd_lane_seq #(
    .N_IF(N_IF), .LANES(LANES), .IDX_W(IDX_W), .TRACE_W(TRACE_W),
    .PKG_W(PKG_W), .OFF_W(OFF_W), .DLY_W(DLY_W), .SUM_W(SUM_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .wl_mode(wl_mode),
    .if_mask(if_mask), .lane_mask(lane_mask),
    .wl_extra(wl_extra), .rd_extra(rd_extra),
    .bck(t_bck), .bdqs(t_bdqs), .pck(t_pck), .pdqs(t_pdqs),
    .div_quot(div_quot), .div_fin(div_fin),
    .rd_idx(rd_idx), .div_go(div_go), .div_dividend(div_dividend),
    .busy(busy), .done(done), .dly_arr(dly_arr)
  );
endmodule

// File: tb/rtd_calc_tb_top.sv
module rtd_calc_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        ld_valid = 1'b0;
  logic        ld_ready;
  logic [3:0]  ld_lane = '0;
  logic [11:0] ld_brd_ck = '0, ld_brd_dqs = '0;
  logic [9:0]  ld_pkg_ck = '0, ld_pkg_dqs = '0;
  logic        wl_mode = 1'b0;
  logic [3:0]  if_mask = '0, lane_mask = '0;
  logic [11:0] wl_extra = 12'd7, rd_extra = 12'd50;
  logic        start = 1'b0;
  logic        busy, done;
  logic [255:0] dly_o;

  rtd_calc dut_i (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_lane(ld_lane), .ld_brd_ck(ld_brd_ck), .ld_brd_dqs(ld_brd_dqs),
    .ld_pkg_ck(ld_pkg_ck), .ld_pkg_dqs(ld_pkg_dqs), .wl_mode(wl_mode),
    .if_mask(if_mask), .lane_mask(lane_mask), .wl_extra(wl_extra),
    .rd_extra(rd_extra), .start(start), .busy(busy), .done(done), .dly_o(dly_o)
  );

  typedef struct packed {
    logic        mode;
    logic [11:0] bck;
    logic [11:0] bdqs;
    logic [9:0]  pck;
    logic [9:0]  pdqs;
    logic [15:0] exp;
  } vec_t;

  // expected values worked out from R2/R3/R4 with wl_extra=7, rd_extra=50
  localparam vec_t VECS [7] = '{
    '{1'b0, 12'd1000, 12'd500,  10'd30,   10'd20,   16'd344},
    '{1'b1, 12'd1000, 12'd400,  10'd30,   10'd20,   16'd114},
    '{1'b1, 12'd100,  12'd900,  10'd200,  10'd10,   16'd67},
    '{1'b1, 12'd0,    12'd2000, 10'd0,    10'd50,   16'd0},
    '{1'b0, 12'd4095, 12'd4095, 10'd1023, 10'd1023, 16'd3430},
    '{1'b0, 12'd6,    12'd0,    10'd0,    10'd0,    16'd50},
    '{1'b1, 12'd0,    12'd7,    10'd5,    10'd0,    16'd11}
  };

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  function automatic logic [15:0] slot(input int g);
    return dly_o[g*16 +: 16];
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic load(input int lane, input int bck, input int bdqs, input int pck, input int pdqs);
    @(negedge clk);
    ld_valid = 1'b1; ld_lane = 4'(lane);
    ld_brd_ck = 12'(bck); ld_brd_dqs = 12'(bdqs);
    ld_pkg_ck = 10'(pck); ld_pkg_dqs = 10'(pdqs);
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic wait_done();
    int guard = 0;
    while (!done && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    chk(done == 1'b1, "R7 done seen (watchdog)", int'(done), 1);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R7 done single pulse", int'(done), 0);
  endtask

  task automatic kick(input logic m, input logic [3:0] ifm, input logic [3:0] lm);
    @(negedge clk);
    wl_mode = m; if_mask = ifm; lane_mask = lm; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R7 busy after start", int'(busy), 1);
  endtask

  task automatic run(input logic m, input logic [3:0] ifm, input logic [3:0] lm);
    kick(m, ifm, lm);
    wait_done();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ld_ready == 1'b1, "R1 ld_ready", int'(ld_ready), 1);
    chk(dly_o == '0, "R1 array zero", int'(slot(0)), 0);

    // vector table: lane 0 only (R2 read, R3 write, R4 clamp)
    for (int i = 0; i < 7; i++) begin
      load(0, int'(VECS[i].bck), int'(VECS[i].bdqs), int'(VECS[i].pck), int'(VECS[i].pdqs));
      run(VECS[i].mode, 4'b0001, 4'b0001);
      chk(slot(0) == VECS[i].exp,
          (VECS[i].exp == 0) ? "R4 clamp" : (VECS[i].mode ? "R3 write sum" : "R2 read sum"),
          int'(slot(0)), int'(VECS[i].exp));
    end

    // fill all lanes: brd_ck = 100*g
    for (int g = 0; g < 16; g++) load(g, g * 100, 0, 0, 0);

    // R5/R6: interface 2, lanes 1 and 3 only
    run(1'b0, 4'b0100, 4'b1010);
    chk(slot(9)  == 16'd196, "R5 slot 9",  int'(slot(9)), 196);
    chk(slot(11) == 16'd229, "R5 slot 11", int'(slot(11)), 229);
    chk(slot(10) == 16'd0,   "R6 masked lane slot 10", int'(slot(10)), 0);
    chk(slot(5)  == 16'd0,   "R6 masked if slot 5", int'(slot(5)), 0);
    chk(slot(0)  == 16'd11,  "R6 old slot 0 kept", int'(slot(0)), 11);

    // R7: empty masks still finish; R6: nothing changes
    run(1'b0, 4'b0000, 4'b1111);
    chk(slot(9) == 16'd196, "R6 empty pass keeps slot 9", int'(slot(9)), 196);

    // R8: load refused during a pass
    kick(1'b0, 4'b1111, 4'b1111);
    ld_valid = 1'b1; ld_lane = 4'd3; ld_brd_ck = 12'd4000; ld_brd_dqs = 12'd0;
    ld_pkg_ck = 10'd0; ld_pkg_dqs = 10'd0;
    chk(ld_ready == 1'b0, "R8 ready low while busy", int'(ld_ready), 0);
    @(negedge clk);
    ld_valid = 1'b0;
    wait_done();
    chk(slot(15) == 16'd294, "R5 slot 15 read", int'(slot(15)), 294);
    chk(slot(0)  == 16'd50,  "R2 slot 0 offset only", int'(slot(0)), 50);
    run(1'b0, 4'b0001, 4'b1000);
    chk(slot(3) == 16'd98, "R8 table unchanged", int'(slot(3)), 98);

    // R3: write mode over all lanes uses the debug offset
    run(1'b1, 4'b1111, 4'b1111);
    for (int g = 0; g < 16; g++)
      chk(slot(g) == 16'((g * 16300) / 1000 + 7), "R3 all-lane write", int'(slot(g)), (g * 16300) / 1000 + 7);

    summary();
  end
endmodule